// File: doc/BRIEF.md
# Accumulator CPU Instruction Sequencer

This block is a multi-cycle fetch and execute core for a small subset of an 8-bit accumulator processor. It has a 16-bit address space and a byte-wide memory port. The port has an address, read data, write data and a one-clock write strobe. Read data must be valid combinationally in the same clock as the address.

The core holds seven 8-bit registers (A, B, C, D, E, H, L), a stack pointer, a program counter and four flags. It fetches an opcode and its immediate bytes, then carries out one of the following:
- register moves
- indirect transfers through HL, with optional post-increment or post-decrement
- high-page I/O transfers
- 16-bit immediate loads
- an absolute jump
- a subroutine call

Every instruction lasts a fixed number of clocks, which is a multiple of four. The core spends each group of four clocks on at most one memory access, made in the first clock of the group. A pulse marks the last clock of each instruction. An opcode outside the subset stops the core for good.

Top module: `acc_seq_core`

## Requirements
- R1: After reset the registers read A=0x11, B=0x00, C=0x00, D=0xFF, E=0x56, H=0x00, L=0x0D, SP=0xFFFE and PC=0x0000. The flags read 4'b1000 ({Z,N,H,C}).
- R2: Opcodes 0x40..0x7F other than 0x76 copy a source into a destination. The destination field is bits 5:3 and the source field is bits 2:0. Codes 0..7 select B, C, D, E, H, L, memory at HL, A. A move between two registers takes 4 clocks.
- R3: A move that reads or writes memory at address HL takes 8 clocks.
- R4: Opcodes 0x06, 0x0E, ..., 0x3E with bits 5:3 not equal to 6 load the next byte into the register selected by bits 5:3, in 8 clocks. Opcode 0x36 writes the next byte to address HL in 12 clocks.
- R5: Opcode 0x22 stores A at HL and 0x32 does the same; 0x2A loads A from HL and 0x3A does the same. After the access, 0x22 and 0x2A add one to HL, while 0x32 and 0x3A subtract one. HL wraps modulo 0x10000, and each of these takes 8 clocks.
- R6: Opcode 0xE0 writes A to address 0xFF00 OR'd with the next byte, and 0xF0 reads that address into A; each takes 12 clocks. Opcodes 0xE2 and 0xF2 do the same transfers with C as the low address byte, in 8 clocks.
- R7: Opcodes 0x01, 0x11, 0x21 and 0x31 load BC, DE, HL or SP from a little-endian immediate word in 12 clocks. Opcode 0xF9 copies HL into SP in 8 clocks.
- R8: Opcode 0xC3 loads PC from a little-endian immediate word in 16 clocks.
- R9: Opcode 0xCD takes 24 clocks. It pushes the address that follows its third byte: the high byte at SP-1, then the low byte at SP-2. SP wraps, and SP ends 2 lower. PC then takes the target.
- R10: Any other opcode, including 0x76, sets the illegal output. The output stays set until reset, and afterwards PC stays at the opcode's address, no write is made and no instruction completes.
- R11: The done output is high only in the final clock of each instruction. The write strobe never lasts two clocks, and PC advances by one, modulo 0x10000, after each byte fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Read data for the current address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe, one clock |
| instr_done_o | output | 1 | High in the last clock of an instruction |
| illegal_o | output | 1 | Sticky unsupported-opcode flag |
| a_o | output | 8 | Register A |
| b_o | output | 8 | Register B |
| c_o | output | 8 | Register C |
| d_o | output | 8 | Register D |
| e_o | output | 8 | Register E |
| h_o | output | 8 | Register H |
| l_o | output | 8 | Register L |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| flags_o | output | 4 | Flags {Z,N,H,C} |

## Verification
The properties assume three things about the inputs:
- memory returns the byte for the driven address within the same clock;
- reset is held low across at least one rising edge;
- the program contains only supported opcodes until the one illegal opcode that is placed on purpose.

The bench meets these with a memory model whose read is purely combinational. It loads a program in which every instruction belongs to the subset and ends with 0x76. It releases reset only after several edges. Because of this, the sticky-stop and single-pulse properties are exercised both during normal execution and after the stop.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NREG   = 8;
    localparam int CYC_W  = 5;   // enough for the longest instruction (24 clocks)
    localparam int MC_W   = 3;

    // Register slot codes as carried in opcode fields
    localparam logic [2:0] REG_B = 3'd0;
    localparam logic [2:0] REG_C = 3'd1;
    localparam logic [2:0] REG_H = 3'd4;
    localparam logic [2:0] REG_L = 3'd5;
    localparam logic [2:0] REG_M = 3'd6;   // memory at HL
    localparam logic [2:0] REG_A = 3'd7;

    typedef enum logic [3:0] {
        K_ILL, K_MOVE, K_LDI8, K_STI8, K_HLX, K_IOI, K_IOC,
        K_LD16, K_SPHL, K_JP, K_CALL
    } kind_t;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rf;
        logic [ADDR_W-1:0]           sp;
        logic [ADDR_W-1:0]           pc;
        logic [3:0]                  flg;
        logic [DATA_W-1:0]           op;
        logic [DATA_W-1:0]           lo;
        logic [DATA_W-1:0]           hi;
        logic [CYC_W-1:0]            cyc;
        logic                        ill;
    } st_t;

    function automatic st_t rst_state();
        st_t s;
        s     = '0;
        // slots 7..0: A, (unused), L, H, E, D, C, B
        s.rf  = {8'h11, 8'h00, 8'h0D, 8'h00, 8'h56, 8'hFF, 8'h00, 8'h00};
        s.sp  = 16'hFFFE;
        s.flg = 4'b1000;
        return s;
    endfunction

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  logic [DATA_W-1:0] op_i,
    output kind_t             kind_o,
    output logic [MC_W-1:0]   mlen_o
);
    always_comb begin
        kind_o = K_ILL;
        mlen_o = 3'd1;
        if (op_i[7:6] == 2'b01) begin
            if (op_i != 8'h76) begin
                kind_o = K_MOVE;
                mlen_o = (op_i[5:3] == REG_M || op_i[2:0] == REG_M) ? 3'd2 : 3'd1;
            end
        end else if (op_i[7:6] == 2'b00 && op_i[2:0] == 3'd6) begin
            if (op_i[5:3] == REG_M) begin
                kind_o = K_STI8;
                mlen_o = 3'd3;
            end else begin
                kind_o = K_LDI8;
                mlen_o = 3'd2;
            end
        end else if (op_i[7:6] == 2'b00 && op_i[3:0] == 4'h1) begin
            kind_o = K_LD16;
            mlen_o = 3'd3;
        end else begin
            case (op_i)
                8'h22, 8'h32, 8'h2A, 8'h3A: begin kind_o = K_HLX;  mlen_o = 3'd2; end
                8'hE0, 8'hF0:               begin kind_o = K_IOI;  mlen_o = 3'd3; end
                8'hE2, 8'hF2:               begin kind_o = K_IOC;  mlen_o = 3'd2; end
                8'hF9:                      begin kind_o = K_SPHL; mlen_o = 3'd2; end
                8'hC3:                      begin kind_o = K_JP;   mlen_o = 3'd4; end
                8'hCD:                      begin kind_o = K_CALL; mlen_o = 3'd6; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_seq_step16.sv
module acc_seq_step16 #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         down_i,
    output logic [W-1:0] res_o
);
    assign res_o = down_i ? (val_i - W'(1)) : (val_i + W'(1));
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter logic [7:0] IO_PAGE = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr_o,
    input  logic [7:0]  mem_rdata_i,
    output logic [7:0]  mem_wdata_o,
    output logic        mem_we_o,
    output logic        instr_done_o,
    output logic        illegal_o,
    output logic [7:0]  a_o,
    output logic [7:0]  b_o,
    output logic [7:0]  c_o,
    output logic [7:0]  d_o,
    output logic [7:0]  e_o,
    output logic [7:0]  h_o,
    output logic [7:0]  l_o,
    output logic [15:0] sp_o,
    output logic [15:0] pc_o,
    output logic [3:0]  flags_o
);
    st_t               q, d;
    logic [DATA_W-1:0] op_sel;
    kind_t             kind;
    logic [MC_W-1:0]   mlen;
    logic [ADDR_W-1:0] hl, pc_nx, hl_nx, sp_nx;
    logic [MC_W-1:0]   mc;
    logic [1:0]        sub;
    logic [2:0]        dst, src;

    // In the opening clock the opcode comes straight from memory
    assign op_sel = (q.cyc == '0) ? mem_rdata_i : q.op;
    assign hl     = {q.rf[REG_H], q.rf[REG_L]};
    assign mc     = q.cyc[CYC_W-1:2];
    assign sub    = q.cyc[1:0];
    assign dst    = q.op[5:3];
    assign src    = q.op[2:0];

    acc_seq_decode u_dec (.op_i(op_sel), .kind_o(kind), .mlen_o(mlen));
    acc_seq_step16 #(.W(ADDR_W)) u_pc (.val_i(q.pc), .down_i(1'b0),    .res_o(pc_nx));
    acc_seq_step16 #(.W(ADDR_W)) u_hl (.val_i(hl),   .down_i(q.op[4]), .res_o(hl_nx));
    acc_seq_step16 #(.W(ADDR_W)) u_sp (.val_i(q.sp), .down_i(1'b1),    .res_o(sp_nx));

    always_comb begin
        d            = q;
        mem_addr_o   = q.pc;
        mem_wdata_o  = '0;
        mem_we_o     = 1'b0;
        instr_done_o = 1'b0;
        if (!q.ill) begin
            d.cyc = q.cyc + CYC_W'(1);
            if (q.cyc == '0) begin
                d.op = mem_rdata_i;
                if (kind == K_ILL) begin
                    d.ill = 1'b1;
                    d.cyc = '0;
                end else begin
                    d.pc = pc_nx;
                end
            end else if (sub == 2'd0) begin
                case (kind)
                    K_MOVE: begin
                        mem_addr_o = hl;
                        if (src == REG_M) begin
                            d.rf[dst] = mem_rdata_i;
                        end else begin
                            mem_we_o    = 1'b1;
                            mem_wdata_o = q.rf[src];
                        end
                    end
                    K_LDI8: begin
                        d.rf[dst] = mem_rdata_i;
                        d.pc      = pc_nx;
                    end
                    K_STI8: begin
                        if (mc == 3'd1) begin
                            d.lo = mem_rdata_i;
                            d.pc = pc_nx;
                        end else begin
                            mem_addr_o  = hl;
                            mem_we_o    = 1'b1;
                            mem_wdata_o = q.lo;
                        end
                    end
                    K_HLX: begin
                        mem_addr_o = hl;
                        if (q.op[3]) begin
                            d.rf[REG_A] = mem_rdata_i;
                        end else begin
                            mem_we_o    = 1'b1;
                            mem_wdata_o = q.rf[REG_A];
                        end
                        d.rf[REG_H] = hl_nx[15:8];
                        d.rf[REG_L] = hl_nx[7:0];
                    end
                    K_IOI, K_IOC: begin
                        if (kind == K_IOI && mc == 3'd1) begin
                            d.lo = mem_rdata_i;
                            d.pc = pc_nx;
                        end else begin
                            mem_addr_o = {IO_PAGE, (kind == K_IOI) ? q.lo : q.rf[REG_C]};
                            if (q.op[4]) begin
                                d.rf[REG_A] = mem_rdata_i;
                            end else begin
                                mem_we_o    = 1'b1;
                                mem_wdata_o = q.rf[REG_A];
                            end
                        end
                    end
                    K_LD16: begin
                        d.pc = pc_nx;
                        if (mc == 3'd1) begin
                            d.lo = mem_rdata_i;
                        end else if (q.op[5:4] == 2'b11) begin
                            d.sp = {mem_rdata_i, q.lo};
                        end else begin
                            d.rf[{q.op[5:4], 1'b0}] = mem_rdata_i;
                            d.rf[{q.op[5:4], 1'b1}] = q.lo;
                        end
                    end
                    K_SPHL: d.sp = hl;
                    K_JP, K_CALL: begin
                        if (mc == 3'd1) begin
                            d.lo = mem_rdata_i;
                            d.pc = pc_nx;
                        end else if (mc == 3'd2) begin
                            d.hi = mem_rdata_i;
                            d.pc = pc_nx;
                        end else if (kind == K_CALL && mc != 3'd5) begin
                            mem_addr_o  = sp_nx;
                            mem_we_o    = 1'b1;
                            mem_wdata_o = (mc == 3'd3) ? q.pc[15:8] : q.pc[7:0];
                            d.sp        = sp_nx;
                        end else begin
                            d.pc = {q.hi, q.lo};
                        end
                    end
                    default: ;
                endcase
            end
            if (kind == K_MOVE && mlen == 3'd1 && q.cyc == CYC_W'(3)) begin
                d.rf[dst] = q.rf[src];
            end
            if (sub == 2'd3 && mc == mlen - 3'd1) begin
                instr_done_o = 1'b1;
                d.cyc        = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_state();
        else        q <= d;
    end

    assign illegal_o = q.ill;
    assign a_o       = q.rf[REG_A];
    assign b_o       = q.rf[REG_B];
    assign c_o       = q.rf[REG_C];
    assign d_o       = q.rf[3'd2];
    assign e_o       = q.rf[3'd3];
    assign h_o       = q.rf[REG_H];
    assign l_o       = q.rf[REG_L];
    assign sp_o      = q.sp;
    assign pc_o      = q.pc;
    assign flags_o   = q.flg;
endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we_o,
    input logic        instr_done_o,
    input logic        illegal_o,
    input logic [15:0] pc_o
);
    // R10
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> illegal_o);
    // R10
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_we_o);
    // R10
    illegal_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable(pc_o));
    // R10
    illegal_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !instr_done_o);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done_o |=> !instr_done_o);
    // R11
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);
endmodule

bind acc_seq_core acc_seq_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_we_o     (mem_we_o),
    .instr_done_o (instr_done_o),
    .illegal_o    (illegal_o),
    .pc_o         (pc_o)
);

// File: tb/sim_acc_seq_core.sv
module sim_acc_seq_core;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  len;
        logic [7:0]  b0, b1, b2;
        logic [4:0]  cyc;
        logic [3:0]  sel;     // 0..7 register slot (6 = memory at maddr), 8 SP, 9 PC
        logic [15:0] maddr;
        logic [15:0] expv;
    } vec_t;

    localparam vec_t TAB [NV] = '{
        '{4'd4, 2'd2, 8'h26, 8'h01, 8'h00, 5'd8,  4'd4, 16'h0000, 16'h0001}, // R4 H=01
        '{4'd4, 2'd2, 8'h2E, 8'h05, 8'h00, 5'd8,  4'd5, 16'h0000, 16'h0005}, // R4 L=05
        '{4'd3, 2'd1, 8'h46, 8'h00, 8'h00, 5'd8,  4'd0, 16'h0000, 16'h005A}, // R3 B<-(HL)
        '{4'd2, 2'd1, 8'h48, 8'h00, 8'h00, 5'd4,  4'd1, 16'h0000, 16'h005A}, // R2 C<-B
        '{4'd2, 2'd1, 8'h7B, 8'h00, 8'h00, 5'd4,  4'd7, 16'h0000, 16'h0056}, // R2 A<-E
        '{4'd3, 2'd1, 8'h77, 8'h00, 8'h00, 5'd8,  4'd6, 16'h0105, 16'h0056}, // R3 (HL)<-A
        '{4'd4, 2'd2, 8'h36, 8'hA5, 8'h00, 5'd12, 4'd6, 16'h0105, 16'h00A5}, // R4 (HL)<-i8
        '{4'd4, 2'd2, 8'h3E, 8'h99, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h0099}, // R4 A=99
        '{4'd5, 2'd1, 8'h22, 8'h00, 8'h00, 5'd8,  4'd6, 16'h0105, 16'h0099}, // R5 store, HL+
        '{4'd5, 2'd1, 8'h32, 8'h00, 8'h00, 5'd8,  4'd6, 16'h0106, 16'h0099}, // R5 store, HL-
        '{4'd4, 2'd2, 8'h36, 8'h77, 8'h00, 5'd12, 4'd6, 16'h0105, 16'h0077}, // R4
        '{4'd5, 2'd1, 8'h2A, 8'h00, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h0077}, // R5 load, HL+
        '{4'd5, 2'd1, 8'h3A, 8'h00, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h0099}, // R5 load, HL-
        '{4'd2, 2'd1, 8'h7D, 8'h00, 8'h00, 5'd4,  4'd7, 16'h0000, 16'h0005}, // R2 A<-L
        '{4'd6, 2'd2, 8'hF0, 8'h81, 8'h00, 5'd12, 4'd7, 16'h0000, 16'h003C}, // R6 read FF81
        '{4'd6, 2'd2, 8'hE0, 8'h90, 8'h00, 5'd12, 4'd6, 16'hFF90, 16'h003C}, // R6 write FF90
        '{4'd4, 2'd2, 8'h0E, 8'h85, 8'h00, 5'd8,  4'd1, 16'h0000, 16'h0085}, // R4 C=85
        '{4'd6, 2'd1, 8'hE2, 8'h00, 8'h00, 5'd8,  4'd6, 16'hFF85, 16'h003C}, // R6 write FF00|C
        '{4'd4, 2'd2, 8'h0E, 8'h84, 8'h00, 5'd8,  4'd1, 16'h0000, 16'h0084}, // R4 C=84
        '{4'd6, 2'd1, 8'hF2, 8'h00, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h00C7}, // R6 read FF00|C
        '{4'd7, 2'd3, 8'h21, 8'h34, 8'h01, 5'd12, 4'd5, 16'h0000, 16'h0034}, // R7 HL=0134
        '{4'd7, 2'd1, 8'hF9, 8'h00, 8'h00, 5'd8,  4'd8, 16'h0000, 16'h0134}, // R7 SP<-HL
        '{4'd7, 2'd3, 8'h31, 8'h00, 8'h00, 5'd12, 4'd8, 16'h0000, 16'h0000}, // R7 SP=0000
        '{4'd7, 2'd3, 8'h01, 8'hCD, 8'hAB, 5'd12, 4'd1, 16'h0000, 16'h00CD}, // R7 BC low first
        '{4'd7, 2'd3, 8'h11, 8'hEF, 8'hBE, 5'd12, 4'd2, 16'h0000, 16'h00BE}, // R7 DE
        '{4'd8, 2'd3, 8'hC3, 8'h40, 8'h00, 5'd16, 4'd9, 16'h0000, 16'h0040}, // R8 jump
        '{4'd9, 2'd3, 8'hCD, 8'h60, 8'h00, 5'd24, 4'd6, 16'hFFFE, 16'h0043}, // R9 low byte at SP-2
        '{4'd5, 2'd1, 8'h32, 8'h00, 8'h00, 5'd8,  4'd6, 16'h0134, 16'h00C7}, // R5
        '{4'd7, 2'd3, 8'h21, 8'h00, 8'h00, 5'd12, 4'd4, 16'h0000, 16'h0000}, // R7 HL=0000
        '{4'd5, 2'd1, 8'h3A, 8'h00, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h0026}, // R5 HL wraps to FFFF
        '{4'd5, 2'd1, 8'h2A, 8'h00, 8'h00, 5'd8,  4'd7, 16'h0000, 16'h0000}  // R5 reads FFFF, wraps to 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we, instr_done, illegal;
    logic [7:0]  a_o, b_o, c_o, d_o, e_o, h_o, l_o;
    logic [15:0] sp_o, pc_o;
    logic [3:0]  flags_o;
    logic [7:0]  mem [1024];
    logic [15:0] pos;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] idx(input logic [15:0] a);
        return {a[15], a[8:0]};
    endfunction

    assign mem_rdata = mem[idx(mem_addr)];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            pos = 16'h0000;
            for (int e = 0; e < NV; e++) begin
                mem[idx(pos)] <= TAB[e].b0;
                if (TAB[e].len > 2'd1) mem[idx(pos + 16'd1)] <= TAB[e].b1;
                if (TAB[e].len > 2'd2) mem[idx(pos + 16'd2)] <= TAB[e].b2;
                if (TAB[e].b0 == 8'hC3 || TAB[e].b0 == 8'hCD) pos = {TAB[e].b2, TAB[e].b1};
                else pos = pos + 16'(TAB[e].len);
            end
            mem[idx(pos)]      <= 8'h76;
            mem[idx(16'h0105)] <= 8'h5A;
            mem[idx(16'hFF81)] <= 8'h3C;
            mem[idx(16'hFF84)] <= 8'hC7;
        end else if (mem_we) begin
            mem[idx(mem_addr)] <= mem_wdata;
        end
    end

    acc_seq_core u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .instr_done_o(instr_done), .illegal_o(illegal),
        .a_o(a_o), .b_o(b_o), .c_o(c_o), .d_o(d_o), .e_o(e_o),
        .h_o(h_o), .l_o(l_o), .sp_o(sp_o), .pc_o(pc_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] obs(input logic [3:0] sel, input logic [15:0] maddr);
        case (sel)
            4'd0: return {8'h00, b_o};
            4'd1: return {8'h00, c_o};
            4'd2: return {8'h00, d_o};
            4'd3: return {8'h00, e_o};
            4'd4: return {8'h00, h_o};
            4'd5: return {8'h00, l_o};
            4'd6: return {8'h00, mem[idx(maddr)]};
            4'd7: return {8'h00, a_o};
            4'd8: return sp_o;
            default: return pc_o;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int  n;
        int  seen;
        bit  hung;
        hung = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, sampled in the first clock after release
        chk("R1 A", {8'h00, a_o}, 16'h0011);
        chk("R1 B", {8'h00, b_o}, 16'h0000);
        chk("R1 C", {8'h00, c_o}, 16'h0000);
        chk("R1 D", {8'h00, d_o}, 16'h00FF);
        chk("R1 E", {8'h00, e_o}, 16'h0056);
        chk("R1 H", {8'h00, h_o}, 16'h0000);
        chk("R1 L", {8'h00, l_o}, 16'h000D);
        chk("R1 SP", sp_o, 16'hFFFE);
        chk("R1 PC", pc_o, 16'h0000);
        chk("R1 flags", {12'h000, flags_o}, 16'h0008);
        chk("R1 illegal", {15'h0, illegal}, 16'h0000);

        for (int e = 0; e < NV && !hung; e++) begin
            n = 1;
            while (!instr_done && n <= 40) begin
                @(negedge clk);
                n++;
            end
            if (!instr_done) begin
                hung = 1'b1;
                errors++;
                $display("FAIL R11 vector %0d no completion actual %0d expected %0d", e, n, TAB[e].cyc);
            end else begin
                @(negedge clk);
                chk($sformatf("R%0d/R11 cycles vector %0d", TAB[e].req, e), 16'(n), 16'(TAB[e].cyc));
                chk($sformatf("R%0d value vector %0d", TAB[e].req, e),
                    obs(TAB[e].sel, TAB[e].maddr), TAB[e].expv);
            end
        end

        if (!hung) begin
            // R9 push high byte at SP-1 (wrapped) and SP restored by two decrements
            chk("R9 high byte at FFFF", {8'h00, mem[idx(16'hFFFF)]}, 16'h0000);
            chk("R9 SP after call", sp_o, 16'hFFFE);
            chk("R5 HL wrapped to 0000", {h_o, l_o}, 16'h0000);
            // R10 illegal opcode 0x76 at 0x0066
            seen = 0;
            repeat (6) begin
                @(negedge clk);
                if (instr_done || mem_we) seen++;
            end
            chk("R10 illegal flag", {15'h0, illegal}, 16'h0001);
            chk("R10 PC held", pc_o, 16'h0066);
            chk("R10 no activity", 16'(seen), 16'h0000);
            chk("R10 stack intact", {8'h00, mem[idx(16'hFFFE)]}, 16'h0043);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            chk("R10 cleared by reset", {15'h0, illegal}, 16'h0000);
            chk("R1 PC after second reset", pc_o, 16'h0000);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule